// File: doc/BRIEF.md
# Split-Access 64-bit Timestamp Timer

This block keeps a free-running 64-bit microsecond timestamp that a 32-bit register bus has to reach one word at a time. A tick enable advances the count. Software reads the upper and lower words through simple read strobes, and the selected word appears on the read data port in the same cycle.

Writes are two-phase. A write to the lower word only parks that word in a shadow register. The write to the upper word then commits the upper word and the parked lower word together, after a fixed commit latency. A clear command commits zero through the same path, and it needs no release. While a commit is pending, a busy flag is raised. Software is expected to poll this flag a bounded number of times before it starts the next write or clear.

A built-in snapshot sequencer produces a coherent 64-bit value while the count keeps running. It takes the lower word, then the upper word, then the lower word again, one clock apart. If the lower word went backwards between the two lower samples, it bumps the upper sample by one.

Top module: `tstamp_split`

## Requirements
- R1: The count advances by exactly one at each clock edge where `tick_i` is 1 and no commit lands, holds when `tick_i` is 0, and wraps from all ones to zero (modulo 2^64).
- R2: Read data is combinational: `rd_hi_i` selects count bits 63:32, `rd_lo_i` selects bits 31:0, `rd_hi_i` wins when both are set, and the data is zero when neither is set.
- R3: A lower-word write (`wr_lo_i`) only updates the shadow word and never changes the running count. The shadow keeps its value after a commit and is zero after reset.
- R4: An upper-word write accepted at edge E loads {`wdata_i`, shadow} into the count at edge E+2. The loaded value replaces any tick at that edge.
- R5: `busy_o` is 1 for exactly the two cycles after an accepted upper-word write or clear, and 0 otherwise.
- R6: `wr_clr_i` commits zero with the same latency as R4. When it arrives together with `wr_hi_i`, the clear wins.
- R7: An upper-word write or clear that arrives while `busy_o` is 1 is dropped and does not alter the pending value.
- R8: A `snap_req_i` accepted at idle edge E samples the low word at E, the high word at E+1 and the low word again at E+2. After E+2, `snap_valid_o` pulses for one cycle and `snap_o` = {high + (second low < first low ? 1 : 0), second low}. Requests made during a sequence are ignored.
- R9: After reset the count is 0, `busy_o` is 0 and `snap_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one increment per cycle |
| wr_lo_i | input | 1 | Lower-word write strobe (stages shadow) |
| wr_hi_i | input | 1 | Upper-word write strobe (commits 64 bits) |
| wr_clr_i | input | 1 | Clear command strobe |
| wdata_i | input | 32 | Write data |
| rd_lo_i | input | 1 | Lower-word read select |
| rd_hi_i | input | 1 | Upper-word read select |
| rdata_o | output | 32 | Read data |
| busy_o | output | 1 | Commit of a write or clear in progress |
| snap_req_i | input | 1 | Start a coherent snapshot |
| snap_valid_o | output | 1 | Snapshot result valid pulse |
| snap_o | output | 64 | Coherent 64-bit snapshot |

## Verification
The bench loads values just below a 32-bit boundary and runs the snapshot with ticks enabled. In that case the low word wraps between the high and second low samples, so a sequencer that skips or inverts the correction returns a value off by 2^32. It stages a low word alone and reads back an unchanged count, which catches a design that writes the low half straight into the counter. It also counts `busy_o` cycle by cycle and fires a second write and a clear into the busy window. A wrong commit latency, or a pending value that gets overwritten, shows up there as a wrong loaded count. The full-ones wrap and the clear-over-write priority are checked as well.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_HI   = 2'd1,
    RD_LO2  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/tstamp_core.sv
module tstamp_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;

  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && tick_i) |=> (cnt_q == $past(cnt_q) + ONE)); // R1
  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/tstamp_commit.sv
module tstamp_commit #(
  parameter int BUS_W = 32,
  parameter int LAT   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic               clr_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic               busy_o,
  output logic               load_o,
  output logic [2*BUS_W-1:0] load_val_o
);
  localparam int LAT_W = $clog2(LAT + 1);
  localparam logic [LAT_W-1:0] LAT_ONE = {{(LAT_W-1){1'b0}}, 1'b1};

  logic [BUS_W-1:0]   shadow_q;
  logic [2*BUS_W-1:0] pend_q;
  logic [LAT_W-1:0]   wait_q;
  logic               accept;

  assign busy_o = (wait_q != '0);
  assign accept = (wr_hi_i || clr_i) && !busy_o;
  assign load_o = (wait_q == LAT_ONE);
  assign load_val_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      shadow_q <= '0;
    else if (wr_lo_i) shadow_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      wait_q <= '0;
    end else if (accept) begin
      pend_q <= clr_i ? '0 : {wdata_i, shadow_q};
      wait_q <= LAT_W'(LAT);
    end else if (busy_o) begin
      wait_q <= wait_q - LAT_ONE;
    end
  end

  AST_BUSY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o); // R5
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !busy_o); // R5
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && clr_i) |=> (load_val_o == '0)); // R6
  AST_DROP_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (wr_hi_i || clr_i)) |=> $stable(load_val_o)); // R7
endmodule

// File: rtl/tstamp_reader.sv
module tstamp_reader
  import tstamp_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [2*BUS_W-1:0] cnt_i,
  output logic               snap_valid_o,
  output logic [2*BUS_W-1:0] snap_o
);
  rd_state_e        st_q;
  logic [BUS_W-1:0] lo1_q;
  logic [BUS_W-1:0] hi_q;
  logic [BUS_W-1:0] lo2;
  logic             wrapped;

  assign lo2     = cnt_i[BUS_W-1:0];
  assign wrapped = (lo2 < lo1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= RD_IDLE;
      lo1_q        <= '0;
      hi_q         <= '0;
      snap_o       <= '0;
      snap_valid_o <= 1'b0;
    end else begin
      snap_valid_o <= 1'b0;
      unique case (st_q)
        RD_IDLE: if (req_i) begin
          lo1_q <= cnt_i[BUS_W-1:0];
          st_q  <= RD_HI;
        end
        RD_HI: begin
          hi_q <= cnt_i[2*BUS_W-1:BUS_W];
          st_q <= RD_LO2;
        end
        RD_LO2: begin
          snap_o       <= {hi_q + {{(BUS_W-1){1'b0}}, wrapped}, lo2};
          snap_valid_o <= 1'b1;
          st_q         <= RD_IDLE;
        end
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  AST_SNAP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_valid_o |=> !snap_valid_o); // R8
  AST_SNAP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_valid_o |-> (snap_o[BUS_W-1:0] == $past(cnt_i[BUS_W-1:0]))); // R8
endmodule

// File: rtl/tstamp_split.sv
module tstamp_split #(
  parameter int BUS_W = 32,
  parameter int LAT   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic               wr_clr_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic               rd_lo_i,
  input  logic               rd_hi_i,
  output logic [BUS_W-1:0]   rdata_o,
  output logic               busy_o,
  input  logic               snap_req_i,
  output logic               snap_valid_o,
  output logic [2*BUS_W-1:0] snap_o
);
  localparam int CNT_W = 2 * BUS_W;

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;

  tstamp_commit #(.BUS_W(BUS_W), .LAT(LAT)) u_commit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_lo_i    (wr_lo_i),
    .wr_hi_i    (wr_hi_i),
    .clr_i      (wr_clr_i),
    .wdata_i    (wdata_i),
    .busy_o     (busy_o),
    .load_o     (load),
    .load_val_o (load_val)
  );

  tstamp_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_o      (cnt)
  );

  tstamp_reader #(.BUS_W(BUS_W)) u_reader (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (snap_req_i),
    .cnt_i        (cnt),
    .snap_valid_o (snap_valid_o),
    .snap_o       (snap_o)
  );

  always_comb begin
    if (rd_hi_i)      rdata_o = cnt[CNT_W-1:BUS_W];
    else if (rd_lo_i) rdata_o = cnt[BUS_W-1:0];
    else              rdata_o = '0;
  end

  AST_LO_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !busy_o && !tick_i) |=> $stable(cnt)); // R3
endmodule

// File: tb/sim_tstamp_split.sv
`timescale 1ns/1ps
module sim_tstamp_split;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0, wr_clr = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_lo = 1'b0, rd_hi = 1'b0, snap_req = 1'b0;
  logic [31:0] rdata;
  logic        busy, snap_valid;
  logic [63:0] snap;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tstamp_split u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wr_clr_i(wr_clr), .wdata_i(wdata), .rd_lo_i(rd_lo), .rd_hi_i(rd_hi),
    .rdata_o(rdata), .busy_o(busy), .snap_req_i(snap_req),
    .snap_valid_o(snap_valid), .snap_o(snap)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read64(output logic [63:0] v);
    @(negedge clk);
    rd_hi = 1'b1; #0.5 v[63:32] = rdata;
    rd_hi = 1'b0; rd_lo = 1'b1; #0.5 v[31:0] = rdata;
    rd_lo = 1'b0;
  endtask

  task automatic stage_lo(input logic [31:0] d);
    @(negedge clk); wr_lo = 1'b1; wdata = d;
    @(negedge clk); wr_lo = 1'b0;
  endtask

  // hi write, then count busy cycles; returns when idle
  task automatic commit_hi(input logic [31:0] d, input string req);
    int nb = 0;
    @(negedge clk); wr_hi = 1'b1; wdata = d;
    @(negedge clk); wr_hi = 1'b0;
    for (int i = 0; i < 10 && busy; i++) begin nb++; @(negedge clk); end
    check(req, 64'(nb), 64'd2);
  endtask

  task automatic load64(input logic [63:0] v);
    stage_lo(v[31:0]);
    commit_hi(v[63:32], "R5");
  endtask

  task automatic t_reset;
    logic [63:0] v;
    read64(v);
    check("R9 count", v, 64'd0);
    check("R9 busy", 64'(busy), 64'd0);
    check("R9 snap_valid", 64'(snap_valid), 64'd0);
  endtask

  task automatic t_shadow_reset;
    logic [63:0] v;
    commit_hi(32'h0000_00A5, "R5");
    read64(v);
    check("R3 shadow zero after reset", v, 64'h0000_00A5_0000_0000);
  endtask

  task automatic t_read_mux;
    load64(64'h1234_5678_9ABC_DEF0);
    @(negedge clk);
    rd_hi = 1'b1; rd_lo = 1'b1; #0.5 check("R2 both", 64'(rdata), 64'h1234_5678);
    rd_hi = 1'b0; rd_lo = 1'b0; #0.5 check("R2 none", 64'(rdata), 64'd0);
    rd_lo = 1'b1; #0.5 check("R2 lo", 64'(rdata), 64'h9ABC_DEF0);
    rd_lo = 1'b0;
  endtask

  task automatic t_lo_only;
    logic [63:0] v;
    stage_lo(32'hDEAD_BEEF);
    repeat (3) @(negedge clk);
    read64(v);
    check("R3 lo write staged only", v, 64'h1234_5678_9ABC_DEF0);
    commit_hi(32'h0000_0001, "R5");
    read64(v);
    check("R4 commit with staged lo", v, 64'h0000_0001_DEAD_BEEF);
    commit_hi(32'h0000_0002, "R5");
    read64(v);
    check("R3 shadow kept after commit", v, 64'h0000_0002_DEAD_BEEF);
  endtask

  task automatic t_latency;
    logic [63:0] v;
    stage_lo(32'h0000_0100);
    @(negedge clk); wr_hi = 1'b1; wdata = 32'h0;
    @(posedge clk);              // E0
    @(negedge clk); wr_hi = 1'b0; tick = 1'b1;
    check("R5 busy c1", 64'(busy), 64'd1);
    @(negedge clk); check("R5 busy c2", 64'(busy), 64'd1);
    @(negedge clk); check("R5 busy c3", 64'(busy), 64'd0);
    tick = 1'b0;                 // loaded at E2, ticked once at E3? no: stopped before E3
    read64(v);
    check("R4 load replaces tick", v, 64'h0000_0000_0000_0100);
    @(negedge clk); tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    read64(v);
    check("R1 five ticks", v, 64'h0000_0000_0000_0105);
    repeat (3) @(negedge clk);
    read64(v);
    check("R1 hold without tick", v, 64'h0000_0000_0000_0105);
  endtask

  task automatic t_wrap;
    logic [63:0] v;
    load64(64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    read64(v);
    check("R1 wrap to zero", v, 64'd0);
  endtask

  task automatic t_drop_busy;
    logic [63:0] v;
    stage_lo(32'h0000_0011);
    @(negedge clk); wr_hi = 1'b1; wdata = 32'h0000_00AA;
    @(negedge clk); wdata = 32'h0000_00BB;          // busy now: dropped
    @(negedge clk); wr_hi = 1'b0; wr_clr = 1'b1;    // still busy: dropped
    @(negedge clk); wr_clr = 1'b0;
    check("R7 idle after one commit", 64'(busy), 64'd0);
    read64(v);
    check("R7 busy writes dropped", v, 64'h0000_00AA_0000_0011);
  endtask

  task automatic t_clear;
    logic [63:0] v;
    int nb = 0;
    @(negedge clk); wr_clr = 1'b1;
    @(negedge clk); wr_clr = 1'b0;
    for (int i = 0; i < 10 && busy; i++) begin nb++; @(negedge clk); end
    check("R6 clear latency", 64'(nb), 64'd2);
    read64(v);
    check("R6 clear", v, 64'd0);
    load64(64'h0000_0042_0000_0042);
    @(negedge clk); wr_clr = 1'b1; wr_hi = 1'b1; wdata = 32'h7777_7777;
    @(negedge clk); wr_clr = 1'b0; wr_hi = 1'b0;
    repeat (2) @(negedge clk);
    read64(v);
    check("R6 clear beats hi write", v, 64'd0);
  endtask

  // tick on: lo1 = V.lo, hi = (V+1).hi, lo2 = (V+2).lo
  task automatic t_snap(input logic [63:0] base, input logic [63:0] exp, input string req);
    load64(base);
    @(negedge clk); tick = 1'b1; snap_req = 1'b1;
    @(posedge clk);              // E0
    @(negedge clk);              // hold req through sequence: must be ignored
    @(negedge clk);
    check({req, " no early valid"}, 64'(snap_valid), 64'd0);
    @(posedge clk);              // E2
    @(negedge clk); snap_req = 1'b0; tick = 1'b0;
    check({req, " valid"}, 64'(snap_valid), 64'd1);
    check({req, " value"}, snap, exp);
    @(negedge clk); check({req, " single pulse"}, 64'(snap_valid), 64'd0);
    @(negedge clk); check({req, " req ignored mid-run"}, 64'(snap_valid), 64'd0);
  endtask

  task automatic t_snap_static;
    load64(64'hCAFE_0001_0000_0123);
    @(negedge clk); snap_req = 1'b1;
    @(negedge clk); snap_req = 1'b0;
    @(negedge clk);
    @(negedge clk); check("R8 static valid", 64'(snap_valid), 64'd1);
    check("R8 static value", snap, 64'hCAFE_0001_0000_0123);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shadow_reset();
    t_read_mux();
    t_lo_only();
    t_latency();
    t_wrap();
    t_drop_busy();
    t_clear();
    t_snap_static();
    t_snap(64'h0000_0007_FFFF_FFFE, 64'h0000_0008_0000_0000, "R8 rollover");
    t_snap(64'h0000_0001_0000_0010, 64'h0000_0001_0000_0012, "R8 no rollover");
    t_snap(64'h0000_0003_FFFF_FFFD, 64'h0000_0003_FFFF_FFFF, "R8 near edge");
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule